// File: doc/BRIEF.md
# Program Status Read Multiplexer

This block builds the byte that a page-programmed memory returns on a host read. When no internal program or erase cycle is running, it passes the array data for the addressed location to the output. While the busy input is high, two bits of the byte become completion status.

The poll bit carries the complement of the same bit of the last byte loaded before programming. The toggle bit changes value from one read access to the next. A host can therefore find out when programming has finished in either of two ways. It can read until the poll bit matches the data it wrote. Or it can read twice and see whether the toggle bit has stopped changing.

The block does not hold the array and does not time the programming. It receives the busy flag, the last loaded byte, the array read data and the two active-low controls, chip enable and output enable. It produces a registered data byte and an enable for an external tristate driver.

Top module: `prog_status_mux`

## Requirements
- R1: `rd_oe` goes high one clock after `ce_n` and `oe_n` are both sampled low. It goes low one clock after either of them is sampled high.
- R2: Whenever `rd_oe` is low, `rd_data` is all zeros. This holds with only `ce_n` low, with only `oe_n` low, and with both high.
- R3: When busy is low during an access, `rd_data` equals the `array_data` sampled one clock earlier. Bits 7 and 6 are included.
- R4: When busy is high during an access, `rd_data` bit 7 (the poll bit) is the complement of bit 7 of `last_byte`.
- R5: When busy is high, `rd_data` bit 6 (the toggle bit) reads 0 on the first access of a busy period. It then alternates on each later access. An access begins when the combined enable goes from inactive to active, and the bit stays constant for the whole of that access, however long it lasts.
- R6: When busy is high during an access, `rd_data` bits 5 to 0 equal the `array_data` sampled one clock earlier.
- R7: A rising edge of busy restarts the toggle sequence. The first access of a new busy period reads 0 in bit 6, whatever the previous period left behind.
- R8: If busy rises while an access is already under way, that access reads 0 in bit 6 from the next clock onward. The following access reads 1.
- R9: After busy falls, the next access returns the full array data. Bit 7 then shows the true value of the stored byte, and bit 6 no longer toggles.
- R10: While `rst_n` is low, `rd_oe` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| busy | input | 1 | High while an internal program or erase cycle runs |
| last_byte | input | DW | Last byte loaded before programming began |
| array_data | input | DW | Array read data for the addressed location |
| rd_data | output | DW | Registered read data |
| rd_oe | output | 1 | Registered enable for the external tristate driver |

## Verification
The hardest case to reach from the ports is busy rising in the middle of an access. In that case the toggle restart and the access count land on different clocks, and a design that only counts access edges would misreport the bit. The bench holds both enables low, checks a plain array read first, then raises busy while the access continues, and checks that bit 6 drops to 0 and stays there. It then starts a fresh access and expects 1. A second stimulus ends one busy period after a single access, leaving the toggle state at 1, and then starts a new period. This shows whether the restart on the busy edge actually happens.

// File: rtl/prog_status_mux.sv
module prog_status_mux #(
  parameter int DW         = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          busy,
  input  logic [DW-1:0] last_byte,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_oe
);

  logic rd_en, rd_en_q, busy_q;
  logic acc_start, busy_start;
  logic tog, tog_nx, shown, shown_nx;
  logic [DW-1:0] data_nx;
  logic unused_bits;

  assign unused_bits = ^last_byte;
  assign rd_en       = !ce_n && !oe_n;
  assign acc_start   = rd_en && !rd_en_q;
  assign busy_start  = busy && !busy_q;

  // tog holds the value the next access will show; shown holds the current one
  always_comb begin
    shown_nx = shown;
    tog_nx   = tog;
    if (busy_start) begin
      shown_nx = 1'b0;
      tog_nx   = rd_en;
    end else if (busy && acc_start) begin
      shown_nx = tog;
      tog_nx   = !tog;
    end
  end

  always_comb begin
    data_nx = array_data;
    if (busy) begin
      data_nx[POLL_BIT]   = !last_byte[POLL_BIT];
      data_nx[TOGGLE_BIT] = shown_nx;
    end
    if (!rd_en) data_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_en_q <= 1'b0;
      busy_q  <= 1'b0;
      tog     <= 1'b0;
      shown   <= 1'b0;
      rd_data <= '0;
      rd_oe   <= 1'b0;
    end else begin
      rd_en_q <= rd_en;
      busy_q  <= busy;
      tog     <= tog_nx;
      shown   <= shown_nx;
      rd_data <= data_nx;
      rd_oe   <= rd_en;
    end
  end

endmodule

// File: rtl/prog_status_mux_chk.sv
module prog_status_mux_chk #(
  parameter int DW         = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          busy,
  input logic [DW-1:0] last_byte,
  input logic [DW-1:0] array_data,
  input logic [DW-1:0] rd_data,
  input logic          rd_oe
);

  logic [1:0] age;
  logic       en_busy;
  logic       unused_lb;

  assign unused_lb = ^last_byte;
  assign en_busy   = !ce_n && !oe_n && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_oe_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n) |=> rd_oe);
  assert_oe_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |=> !rd_oe);
  assert_zero_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rd_data == '0));
  assert_idle_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !busy) |=> (rd_data == $past(array_data)));
  assert_poll_inverted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_busy |=> (rd_data[POLL_BIT] == !$past(last_byte[POLL_BIT])));
  assert_toggle_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && en_busy && $past(en_busy)) |=> $stable(rd_data[TOGGLE_BIT]));
  assert_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_busy |=> (rd_data[TOGGLE_BIT-1:0] == $past(array_data[TOGGLE_BIT-1:0])));

endmodule

bind prog_status_mux prog_status_mux_chk #(
  .DW(DW), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT)
) u_chk (.*);

// File: tb/tb_prog_status_mux.sv
module tb_prog_status_mux;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ce_n, oe_n, busy;
  logic [7:0] last_byte, array_data;
  logic [7:0] rd_data;
  logic       rd_oe;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  prog_status_mux dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .busy(busy),
    .last_byte(last_byte), .array_data(array_data),
    .rd_data(rd_data), .rd_oe(rd_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] busy_val(input logic [7:0] lb, input logic [7:0] arr, input logic t);
    return {~lb[7], t, arr[5:0]};
  endfunction

  task automatic access(input int len, output logic [7:0] d_first, output logic [7:0] d_last,
                        output logic oe_first);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) begin d_first = rd_data; oe_first = rd_oe; end
      d_last = rd_data;
    end
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; busy = 1'b0;
    last_byte = 8'h00; array_data = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R10 oe in reset", {7'd0, rd_oe}, 8'h00);
    chk("R10 data in reset", rd_data, 8'h00);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_idle_reads;
    logic [7:0] f, l; logic o;
    array_data = 8'hC5; access(1, f, l, o);
    chk("R1 oe on", {7'd0, o}, 8'h01);
    chk("R3 idle C5", f, 8'hC5);
    chk("R1 oe off", {7'd0, rd_oe}, 8'h00);
    chk("R2 zero after release", rd_data, 8'h00);
    array_data = 8'h7E; access(3, f, l, o);
    chk("R3 idle 7E", l, 8'h7E);
    array_data = 8'h00; access(1, f, l, o);
    chk("R3 idle 00", f, 8'h00);
  endtask

  task automatic t_half_enable;
    array_data = 8'hAA;
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    chk("R2 ce only oe", {7'd0, rd_oe}, 8'h00);
    chk("R2 ce only data", rd_data, 8'h00);
    ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    chk("R2 oe only oe", {7'd0, rd_oe}, 8'h00);
    chk("R2 oe only data", rd_data, 8'h00);
    oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_toggle;
    logic [7:0] f, l; logic o;
    last_byte = 8'h5A; array_data = 8'h2B;
    @(negedge clk); busy = 1'b1;
    for (int k = 0; k < 4; k++) begin
      access(k == 1 ? 5 : 1, f, l, o);
      chk("R5 toggle seq", f, busy_val(8'h5A, 8'h2B, k[0]));
      if (k == 1) chk("R5 steady in long access", l, f);
    end
    chk("R4 poll bit inverted", {7'd0, f[7]}, 8'h01);
    chk("R6 low bits", {2'b00, f[5:0]}, 8'h2B);
    last_byte = 8'hA5; array_data = 8'h1C;
    access(1, f, l, o);
    chk("R4 poll bit lb=A5", f, busy_val(8'hA5, 8'h1C, 1'b0));
    busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_restart;
    logic [7:0] f, l; logic o;
    last_byte = 8'h80; array_data = 8'h15;
    @(negedge clk); busy = 1'b1;
    access(1, f, l, o);
    chk("R7 first period", f, busy_val(8'h80, 8'h15, 1'b0));
    busy = 1'b0;
    repeat (2) @(negedge clk);
    busy = 1'b1;
    access(1, f, l, o);
    chk("R7 restart reads 0", f, busy_val(8'h80, 8'h15, 1'b0));
    access(1, f, l, o);
    chk("R7 then 1", f, busy_val(8'h80, 8'h15, 1'b1));
    busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_mid_access;
    logic [7:0] f, l; logic o;
    last_byte = 8'h80; array_data = 8'h7C;
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    chk("R3 before busy", rd_data, 8'h7C);
    busy = 1'b1;
    @(negedge clk);
    chk("R8 busy mid access", rd_data, 8'h3C);
    @(negedge clk);
    chk("R8 held", rd_data, 8'h3C);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    access(1, f, l, o);
    chk("R8 next access", f, 8'h7C);
    busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_complete;
    logic [7:0] f, l; logic o;
    last_byte = 8'hC3; array_data = 8'hC3;
    @(negedge clk); busy = 1'b1;
    access(1, f, l, o);
    chk("R9 busy read", f, 8'h03);
    busy = 1'b0;
    access(1, f, l, o);
    chk("R9 done read", f, 8'hC3);
    access(1, f, l, o);
    chk("R9 no toggle", f, 8'hC3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_reads();
    t_half_enable();
    t_toggle();
    t_restart();
    t_mid_access();
    t_complete();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule